// File: doc/BRIEF.md
# SD Host Single-Address DMA Transfer Engine

This block is the data mover of an SD host controller that uses plain single-address DMA. Software loads a start address, a block size with a boundary selector, a block count and a transfer mode word. The engine then moves 32-bit words one at a time, either from the card receive stream into system memory or from system memory into the card transmit stream. The memory port and both card-side streams are valid/ready handshakes.

The address advances by four bytes per word. When the next address lands on a multiple of the selected boundary and more words remain, the engine stops and raises a DMA boundary flag. It carries on when software writes the address register again, from whatever address was written. After the final word it raises a transfer-complete flag. A card error input aborts the transfer and raises an error summary flag, which outranks the other two in the encoded event output. Status bits are cleared by writing ones to them.

Top module: `sd_sdma_engine`

## Requirements
- R1: After reset the status word is 0, busy and stalled are 0, the current address is 0 and the remaining block count is 0.
- R2: In the read direction (transfer mode bit 4 = 1) word n taken from the card receive stream is written to memory at start address + 4n, and the address readback ends at start + 4 times the word count.
- R3: In the write direction (transfer mode bit 4 = 0) words fetched from memory at start + 4n are sent to the card transmit stream in order.
- R4: With multi-block select (transfer mode bit 5) clear, exactly one block of ceil(size/4) words moves whatever the count register holds; block size is register 1 bits [11:0] in bytes.
- R5: With multi-block select and count enable (transfer mode bit 1) set, the count register (register 2) gives the number of blocks and decrements by one after each block, ending at 0; with count enable clear it never changes.
- R6: When the next address is a multiple of 4 KiB shifted left by register 1 bits [14:12] and words remain, the engine stalls, sets status bit 3, and makes no memory or card handshake while stalled; the final word never stalls.
- R7: An address write (register 0) while stalled loads that address and resumes from it; address writes while words are moving are ignored.
- R8: After the final word status bit 1 sets and busy drops.
- R9: A write to register 4 clears exactly the status bits set to 1 in the written data.
- R10: Writing transfer mode with bit 0 set starts a transfer only when the DMA select field (register 5 bits [1:0]) is 00.
- R11: The card error input while busy ends the transfer and sets status bit 15; the event code is 3 when bit 15 is set, else 2 when bit 3 is set, else 1 when bit 1 is set, else 0; the interrupt output is high while any status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 address, 1 size/boundary, 2 count, 3 mode, 4 status clear, 5 DMA select |
| reg_wdata | input | 32 | Register write data |
| err_in | input | 1 | Card-side error indication |
| cur_addr | output | 32 | Running system address |
| blk_left | output | 16 | Remaining block count |
| busy | output | 1 | Transfer in progress (including stalled) |
| stalled | output | 1 | Paused at an address boundary |
| sts | output | 16 | Status word: bit 1 complete, bit 3 boundary, bit 15 error |
| evt_code | output | 2 | Highest-priority pending event |
| irq | output | 1 | Any status bit set |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted (read data valid this cycle) |
| mem_req_write | output | 1 | 1 = memory write, 0 = memory read |
| mem_req_addr | output | 32 | Memory request address |
| mem_req_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| card_in_valid | input | 1 | Card receive word valid |
| card_in_ready | output | 1 | Card receive word taken |
| card_in_data | input | 32 | Card receive word |
| card_out_valid | output | 1 | Card transmit word valid |
| card_out_ready | input | 1 | Card transmit word taken |
| card_out_data | output | 32 | Card transmit word |

## Verification
A register write sampled at a rising edge takes effect at that edge, so a start, resume or status clear is visible at the next falling edge, where the bench samples. In the read direction a word moves in the same cycle its memory and card handshakes coincide, and the address, count, stall and complete indications all update at the edge ending that cycle; in the write direction each word needs a fetch cycle and then a send cycle. The bench records every handshake at the falling edge before the edge that commits it and compares address and data against the word index, so results are checked in the cycle they become due rather than after a fixed delay.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
   typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_MOVE = 2'd1, ST_HOLD = 2'd2} sdma_state_t;

   localparam logic [2:0] SEL_ADDR  = 3'd0;
   localparam logic [2:0] SEL_SIZE  = 3'd1;
   localparam logic [2:0] SEL_COUNT = 3'd2;
   localparam logic [2:0] SEL_MODE  = 3'd3;
   localparam logic [2:0] SEL_CLEAR = 3'd4;
   localparam logic [2:0] SEL_DSEL  = 3'd5;

   localparam int BIT_DONE = 1;
   localparam int BIT_BND  = 3;
   localparam int BIT_ERR  = 15;
endpackage

// File: rtl/sdma_bound_chk.sv
module sdma_bound_chk #(
   parameter int AW        = 32,
   parameter int BASE_LOG2 = 12
) (
   input  logic [AW-1:0] nxt_addr,
   input  logic [2:0]    bsel,
   output logic          on_bound
);
   generate
      if (BASE_LOG2 + 7 > AW) begin : g_bad_width
         $error("sdma_bound_chk: address too narrow for largest boundary");
      end
   endgenerate

   logic [AW-1:0] hit;
   generate
      for (genvar b = 0; b < AW; b++) begin : g_bit
         if (b < BASE_LOG2) begin : g_low
            assign hit[b] = nxt_addr[b];
         end else if (b < BASE_LOG2 + 7) begin : g_mid
            assign hit[b] = nxt_addr[b] && (b < (BASE_LOG2 + int'(bsel)));
         end else begin : g_high
            assign hit[b] = 1'b0;
         end
      end
   endgenerate

   assign on_bound = ~|hit;
endmodule

// File: rtl/sdma_word_mover.sv
module sdma_word_mover #(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic          dir_rd,
   input  logic [AW-1:0] addr,
   output logic          word_done,
   output logic          mem_req_valid,
   input  logic          mem_req_ready,
   output logic          mem_req_write,
   output logic [AW-1:0] mem_req_addr,
   output logic [DW-1:0] mem_req_wdata,
   input  logic [DW-1:0] mem_rdata,
   input  logic          card_in_valid,
   output logic          card_in_ready,
   input  logic [DW-1:0] card_in_data,
   output logic          card_out_valid,
   input  logic          card_out_ready,
   output logic [DW-1:0] card_out_data
);
   logic          have_q;
   logic [DW-1:0] hold_q;

   always_comb begin
      mem_req_addr  = addr;
      mem_req_write = dir_rd;
      mem_req_wdata = card_in_data;
      card_out_data = hold_q;
      if (dir_rd) begin
         mem_req_valid  = go && card_in_valid;
         card_in_ready  = go && mem_req_ready;
         card_out_valid = 1'b0;
         word_done      = go && card_in_valid && mem_req_ready;
      end else begin
         mem_req_valid  = go && !have_q;
         card_in_ready  = 1'b0;
         card_out_valid = go && have_q;
         word_done      = go && have_q && card_out_ready;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_q <= 1'b0;
         hold_q <= '0;
      end else if (!go || dir_rd) begin
         have_q <= 1'b0;
      end else if (!have_q && mem_req_ready) begin
         have_q <= 1'b1;
         hold_q <= mem_rdata;
      end else if (have_q && card_out_ready) begin
         have_q <= 1'b0;
      end
   end
endmodule

// File: rtl/sdma_status.sv
module sdma_status #(
   parameter int SW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          set_done,
   input  logic          set_bnd,
   input  logic          set_err,
   input  logic          clr_we,
   input  logic [SW-1:0] clr_mask,
   output logic [SW-1:0] sts,
   output logic [1:0]    evt_code,
   output logic          irq
);
   import sdma_pkg::*;

   generate
      if (SW <= BIT_ERR) begin : g_bad_sw
         $error("sdma_status: status word too narrow");
      end
   endgenerate

   logic [SW-1:0] set_vec;
   always_comb begin
      set_vec = '0;
      set_vec[BIT_DONE] = set_done;
      set_vec[BIT_BND]  = set_bnd;
      set_vec[BIT_ERR]  = set_err;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sts <= '0;
      else        sts <= (sts & ~(clr_we ? clr_mask : '0)) | set_vec;
   end

   always_comb begin
      if (sts[BIT_ERR])       evt_code = 2'd3;
      else if (sts[BIT_BND])  evt_code = 2'd2;
      else if (sts[BIT_DONE]) evt_code = 2'd1;
      else                    evt_code = 2'd0;
   end
   assign irq = |sts;
endmodule

// File: rtl/sd_sdma_engine.sv
module sd_sdma_engine #(
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter int CW        = 16,
   parameter int SZW       = 12,
   parameter int SW        = 16,
   parameter int BASE_LOG2 = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [2:0]    reg_sel,
   input  logic [31:0]   reg_wdata,
   input  logic          err_in,
   output logic [AW-1:0] cur_addr,
   output logic [CW-1:0] blk_left,
   output logic          busy,
   output logic          stalled,
   output logic [SW-1:0] sts,
   output logic [1:0]    evt_code,
   output logic          irq,
   output logic          mem_req_valid,
   input  logic          mem_req_ready,
   output logic          mem_req_write,
   output logic [AW-1:0] mem_req_addr,
   output logic [DW-1:0] mem_req_wdata,
   input  logic [DW-1:0] mem_rdata,
   input  logic          card_in_valid,
   output logic          card_in_ready,
   input  logic [DW-1:0] card_in_data,
   output logic          card_out_valid,
   input  logic          card_out_ready,
   output logic [DW-1:0] card_out_data
);
   import sdma_pkg::*;

   localparam int STEP = DW / 8;
   localparam int OFW  = SZW + 1;

   generate
      if (DW % 8 != 0 || DW < 8) begin : g_bad_dw
         $error("sd_sdma_engine: data width must be whole bytes");
      end
      if (AW > 32 || CW > 32 || SZW > 12) begin : g_bad_reg
         $error("sd_sdma_engine: register fields exceed write port");
      end
   endgenerate

   sdma_state_t   st_q;
   logic [AW-1:0] addr_q;
   logic [SZW-1:0] size_q;
   logic [2:0]    bsel_q;
   logic [CW-1:0] cnt_q;
   logic [OFW-1:0] boff_q;
   logic          rd_q, multi_q, cen_q;
   logic [1:0]    dsel_q;

   logic          word_done, on_bound, blk_end, last_blk;
   logic          set_done, set_bnd, set_err;
   logic [AW-1:0] nxt_addr;
   logic [OFW-1:0] nxt_off;

   assign nxt_addr = addr_q + AW'(STEP);
   assign nxt_off  = boff_q + OFW'(STEP);
   assign blk_end  = nxt_off >= {1'b0, size_q};
   assign last_blk = !multi_q || (cen_q && cnt_q <= CW'(1));

   sdma_bound_chk #(.AW(AW), .BASE_LOG2(BASE_LOG2)) u_bound (
      .nxt_addr (nxt_addr),
      .bsel     (bsel_q),
      .on_bound (on_bound)
   );

   sdma_word_mover #(.AW(AW), .DW(DW)) u_mover (
      .clk            (clk),
      .rst_n          (rst_n),
      .go             (st_q == ST_MOVE),
      .dir_rd         (rd_q),
      .addr           (addr_q),
      .word_done      (word_done),
      .mem_req_valid  (mem_req_valid),
      .mem_req_ready  (mem_req_ready),
      .mem_req_write  (mem_req_write),
      .mem_req_addr   (mem_req_addr),
      .mem_req_wdata  (mem_req_wdata),
      .mem_rdata      (mem_rdata),
      .card_in_valid  (card_in_valid),
      .card_in_ready  (card_in_ready),
      .card_in_data   (card_in_data),
      .card_out_valid (card_out_valid),
      .card_out_ready (card_out_ready),
      .card_out_data  (card_out_data)
   );

   assign set_err  = err_in && (st_q != ST_IDLE);
   assign set_done = !set_err && word_done && blk_end && last_blk;
   assign set_bnd  = !set_err && word_done && !(blk_end && last_blk) && on_bound;

   sdma_status #(.SW(SW)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_done (set_done),
      .set_bnd  (set_bnd),
      .set_err  (set_err),
      .clr_we   (reg_we && reg_sel == SEL_CLEAR),
      .clr_mask (reg_wdata[SW-1:0]),
      .sts      (sts),
      .evt_code (evt_code),
      .irq      (irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         addr_q  <= '0;
         size_q  <= '0;
         bsel_q  <= '0;
         cnt_q   <= '0;
         boff_q  <= '0;
         rd_q    <= 1'b0;
         multi_q <= 1'b0;
         cen_q   <= 1'b0;
         dsel_q  <= '0;
      end else if (set_err) begin
         st_q <= ST_IDLE;
      end else begin
         case (st_q)
            ST_IDLE: if (reg_we) begin
               case (reg_sel)
                  SEL_ADDR:  addr_q <= reg_wdata[AW-1:0];
                  SEL_SIZE: begin
                     size_q <= reg_wdata[SZW-1:0];
                     bsel_q <= reg_wdata[14:12];
                  end
                  SEL_COUNT: cnt_q  <= reg_wdata[CW-1:0];
                  SEL_DSEL:  dsel_q <= reg_wdata[1:0];
                  SEL_MODE: begin
                     rd_q    <= reg_wdata[4];
                     multi_q <= reg_wdata[5];
                     cen_q   <= reg_wdata[1];
                     boff_q  <= '0;
                     if (reg_wdata[0] && dsel_q == 2'b00) st_q <= ST_MOVE;
                  end
                  default: ;
               endcase
            end
            ST_MOVE: if (word_done) begin
               addr_q <= nxt_addr;
               if (blk_end) begin
                  boff_q <= '0;
                  if (cen_q && cnt_q != '0) cnt_q <= cnt_q - CW'(1);
               end else begin
                  boff_q <= nxt_off;
               end
               if (blk_end && last_blk) st_q <= ST_IDLE;
               else if (on_bound)       st_q <= ST_HOLD;
            end
            ST_HOLD: if (reg_we && reg_sel == SEL_ADDR) begin
               addr_q <= reg_wdata[AW-1:0];
               st_q   <= ST_MOVE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign cur_addr = addr_q;
   assign blk_left = cnt_q;
   assign busy     = st_q != ST_IDLE;
   assign stalled  = st_q == ST_HOLD;

   // R6: no traffic at either edge while paused at a boundary
   p_quiet_in_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      stalled |-> !mem_req_valid && !card_out_valid && !card_in_ready);

   // R6: entering the pause always leaves the boundary flag set
   p_flag_on_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stalled) |-> sts[BIT_BND]);

   // R8 and R11: a transfer only ends with complete or error recorded
   p_end_flagged_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> sts[BIT_DONE] || sts[BIT_ERR]);

   // R5: during a transfer the count only holds or drops by one
   p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy) && busy |-> blk_left == $past(blk_left) || blk_left == $past(blk_left) - CW'(1));

   // R7: the address moves only by one word while transferring
   p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(st_q) == ST_MOVE && !$past(set_err) |-> cur_addr == $past(cur_addr) || cur_addr == $past(cur_addr) + AW'(STEP));

   // R11: error outranks every other event
   p_err_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
      sts[BIT_ERR] |-> evt_code == 2'd3);
endmodule

// File: tb/sd_sdma_engine_tb_top.sv
module sd_sdma_engine_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_sel = '0;
   logic [31:0] reg_wdata = '0;
   logic        err_in = 1'b0;
   logic [31:0] cur_addr;
   logic [15:0] blk_left;
   logic        busy, stalled, irq;
   logic [15:0] sts;
   logic [1:0]  evt_code;
   logic        mem_req_valid, mem_req_write, card_in_ready, card_out_valid;
   logic        mem_req_ready = 1'b1;
   logic        card_in_valid = 1'b0;
   logic        card_out_ready = 1'b1;
   logic [31:0] mem_req_addr, mem_req_wdata, mem_rdata, card_in_data, card_out_data;

   localparam logic [31:0] KEY = 32'h5A5A_5A5A;

   always #2 clk = ~clk;

   sd_sdma_engine dut_i (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .err_in(err_in), .cur_addr(cur_addr), .blk_left(blk_left), .busy(busy), .stalled(stalled),
      .sts(sts), .evt_code(evt_code), .irq(irq),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
      .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata), .mem_rdata(mem_rdata),
      .card_in_valid(card_in_valid), .card_in_ready(card_in_ready), .card_in_data(card_in_data),
      .card_out_valid(card_out_valid), .card_out_ready(card_out_ready), .card_out_data(card_out_data)
   );

   int          n_run = 0, n_fail = 0;
   int          nw = 0, bad_data = 0;
   logic        mon_on = 1'b0;
   logic [31:0] base = '0;

   assign mem_rdata    = mem_req_addr ^ KEY;
   assign card_in_data = 32'hC0DE_0000 | nw;

   always @(negedge clk) begin
      if (mon_on) begin
         if (card_in_valid && card_in_ready) begin
            if (!mem_req_valid || !mem_req_write || mem_req_addr != base + 4*nw ||
                mem_req_wdata != (32'hC0DE_0000 | nw)) bad_data++;
            nw++;
         end else if (card_out_valid && card_out_ready) begin
            if (card_out_data != ((base + 4*nw) ^ KEY)) bad_data++;
            nw++;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] s, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_sel = s; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   typedef struct packed {
      logic        rd;
      logic        multi;
      logic        cen;
      logic [15:0] cnt;
      logic [11:0] size;
      logic [2:0]  bsel;
      logic [31:0] addr;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 1'b0, 1'b1, 16'd5, 12'd16, 3'd0, 32'h1000_0100},
      '{1'b0, 1'b0, 1'b0, 16'd3, 12'd10, 3'd0, 32'h0000_2000},
      '{1'b1, 1'b1, 1'b1, 16'd3, 12'd8,  3'd0, 32'h0000_0FF8},
      '{1'b0, 1'b1, 1'b1, 16'd2, 12'd12, 3'd0, 32'h0000_1FFC},
      '{1'b1, 1'b1, 1'b1, 16'd4, 12'd4,  3'd7, 32'h0007_FFF8},
      '{1'b1, 1'b1, 1'b1, 16'd3, 12'd4,  3'd1, 32'h0000_2FF8},
      '{1'b1, 1'b0, 1'b1, 16'd1, 12'd8,  3'd0, 32'h0000_0FF8}
   };

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(sts == 0 && !busy && !stalled, "R1 status/busy", {sts, busy, stalled}, 0);
      chk(cur_addr == 0 && blk_left == 0, "R1 addr/count", {cur_addr, blk_left}, 0);

      for (int v = 0; v < NV; v++) begin
         vec_t t = VECS[v];
         int wpb = (int'(t.size) + 3) / 4;
         int blocks = t.multi ? int'(t.cnt) : 1;
         int nexp = wpb * blocks;
         int sexp = 0, sgot = 0, left_exp;
         logic [31:0] a = t.addr;
         logic [31:0] msk = (32'h1000 << t.bsel) - 1;
         for (int w = 0; w < nexp; w++) begin
            a = a + 4;
            if (w < nexp - 1 && (a & msk) == 0) sexp++;
         end
         left_exp = t.cen ? int'(t.cnt) - blocks : int'(t.cnt);
         nw = 0; bad_data = 0; base = t.addr; card_in_valid = 1'b1; mon_on = 1'b1;
         wr(3'd0, t.addr);
         wr(3'd1, {17'd0, t.bsel, t.size});
         wr(3'd2, {16'd0, t.cnt});
         wr(3'd3, {26'd0, t.multi, t.rd, 2'b00, t.cen, 1'b1});
         for (int i = 0; i < 5000 && busy; i++) begin
            if (stalled) begin
               sgot++;
               wr(3'd4, 32'h8);
               wr(3'd0, cur_addr);
            end else @(negedge clk);
         end
         mon_on = 1'b0;
         chk(nw == nexp, t.rd ? "R2 word count" : "R3 word count", nw, nexp);
         chk(bad_data == 0, t.rd ? "R2 addr/data" : "R3 addr/data", bad_data, 0);
         chk(cur_addr == t.addr + 4*nexp, "R2 final address", cur_addr, t.addr + 4*nexp);
         chk(int'(blk_left) == left_exp, t.multi ? "R5 remaining count" : "R4 single block count", blk_left, left_exp);
         chk(sgot == sexp, "R6 boundary stalls", sgot, sexp);
         chk(sts[1] && !busy, "R8 complete flag", {sts, busy}, 16'h2);
         wr(3'd4, 32'hFFFF);
         chk(sts == 0, "R9 clear all", sts, 0);
      end

      // R10 non-zero DMA select blocks the start
      wr(3'd5, 32'h2);
      wr(3'd3, 32'h11);
      @(negedge clk);
      chk(!busy, "R10 no start with select 10", busy, 0);
      wr(3'd5, 32'h0);

      // R7 address write ignored while words are moving
      card_in_valid = 1'b0;
      wr(3'd0, 32'h4000);
      wr(3'd1, 32'd16);
      wr(3'd3, 32'h13);
      wr(3'd0, 32'h9000);
      chk(busy && cur_addr == 32'h4000, "R7 write ignored while moving", cur_addr, 32'h4000);
      card_in_valid = 1'b1;
      for (int i = 0; i < 100 && busy; i++) @(negedge clk);
      chk(cur_addr == 32'h4010, "R7 moving transfer unaffected", cur_addr, 32'h4010);
      wr(3'd4, 32'hFFFF);

      // R6/R7/R9/R11 stall, resume at a new address, priorities
      wr(3'd0, 32'h0FF8);
      wr(3'd1, 32'd8);
      wr(3'd2, 32'd2);
      wr(3'd3, 32'h33);
      for (int i = 0; i < 100 && !stalled; i++) @(negedge clk);
      chk(stalled && cur_addr == 32'h1000, "R6 stall at boundary", cur_addr, 32'h1000);
      @(negedge clk);
      chk(!mem_req_valid && !card_in_ready, "R6 no handshake while stalled", {mem_req_valid, card_in_ready}, 0);
      chk(evt_code == 2'd2 && irq, "R11 boundary event code", evt_code, 2);
      wr(3'd0, 32'h5000);
      chk(busy && mem_req_valid && mem_req_addr == 32'h5000, "R7 resume at written address", mem_req_addr, 32'h5000);
      for (int i = 0; i < 100 && busy; i++) @(negedge clk);
      chk(cur_addr == 32'h5008 && blk_left == 0, "R7 resumed transfer finished", cur_addr, 32'h5008);
      wr(3'd4, 32'h8);
      chk(sts == 16'h2, "R9 clear only written bits", sts, 16'h2);
      chk(evt_code == 2'd1 && irq, "R11 complete event code", evt_code, 1);

      // R11 error abort with complete still pending
      card_in_valid = 1'b0;
      wr(3'd0, 32'h6000);
      wr(3'd1, 32'd4);
      wr(3'd2, 32'd4);
      wr(3'd3, 32'h33);
      @(negedge clk);
      err_in = 1'b1;
      @(negedge clk);
      err_in = 1'b0;
      chk(!busy && sts == 16'h8002, "R11 error aborts", sts, 16'h8002);
      chk(evt_code == 2'd3 && irq, "R11 error outranks", evt_code, 3);
      wr(3'd4, 32'hFFFF);
      chk(!irq && evt_code == 0, "R11 irq drops when clear", irq, 0);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule